// File: doc/BRIEF.md
# Embedded Controller Host Mailbox Channel

This block is a byte-wide mailbox that connects a host I/O port to an embedded-controller core. The host reaches it at two I/O locations, selected by one address line. One is a command/status port: writes land as commands and reads return status. The other is a data port. The core reaches it through a small register bus with eight word locations. The channel holds three registers: an output buffer that the core fills and the host drains, an input buffer that the host fills and the core drains, and a status byte that both sides can see.

Two state machines track the buffers. The output machine has the states `OB_EMPTY`, `OB_FULL_IRQ`, `OB_FULL_SMI` and `OB_FULL_SCI`. A core write to any of the three output-buffer aliases moves it from any state to the full state of the chosen interrupt kind. A host data read moves it from a full state to `OB_EMPTY`. The input machine has the states `IB_EMPTY` and `IB_FULL`. A host write to either port moves it to `IB_FULL`. A core read of the input buffer moves it back to `IB_EMPTY`. In both machines the filling event wins when it meets the draining event in the same cycle.

A configuration bit selects the operating mode. In compatible mode the core writes the user status bits directly, and every output alias raises the plain IRQ. In enhanced mode the direct status write is ignored. The core instead sets and clears user status bits through two mask registers. The SMI and SCI aliases then steer the output-full indication onto the matching host line.

Top module: `ec_mailbox`

Core register map (`cor_addr`): 0 output buffer with IRQ, 1 output buffer with SMI, 2 output buffer with SCI, 3 input buffer (read), 4 status (read, direct write), 5 configuration (bit 0 = enhanced mode), 6 status set mask, 7 status clear mask. Reads of 0 to 2 return the output buffer, and reads of 6 and 7 return zero.

## Requirements
- R1: After reset the status byte reads 0x00, the configuration reads 0x00 (compatible mode), and `host_irq`, `host_smi`, `host_sci`, `irq_ibf` and `irq_obe` are all low.
- R2: A core write to address 0 sets status bit 0 (output full) from the next cycle. A host read of the data port (`hst_a`=0) returns the byte and clears bit 0 at the following edge. A host read of the status port (`hst_a`=1) changes no state.
- R3: A host write to either port sets status bit 1 (input full) and stores the byte. Status bit 3 becomes 1 for the command port (`hst_a`=1) and 0 for the data port, and keeps that value after the buffer empties. A core read of address 3 returns the byte and clears bit 1.
- R4: A host write while bit 1 is already set replaces the stored byte and leaves bit 1 set.
- R5: `irq_ibf` equals status bit 1. `irq_obe` is high for exactly one cycle, the cycle after a host data read that empties a full output buffer.
- R6: In enhanced mode a write to address 1 raises `host_smi`, and a write to address 2 raises `host_sci`, in place of `host_irq`. The line stays high while the buffer is full and drops after the host data read. At most one host line is high at any time.
- R7: In compatible mode writes to addresses 1 and 2 load the output buffer and raise only `host_irq`.
- R8: In compatible mode a write to address 4 loads status bits 7, 6, 5, 4 and 2 from the written byte and leaves bits 0, 1 and 3 under hardware control.
- R9: In enhanced mode a write to address 4 has no effect. A write to address 6 sets each user bit (7:4, 2) that is 1 in the data, and a write to address 7 clears each user bit that is 1 in the data.
- R10: A core output write and a host data read in the same cycle leave the buffer full with the new byte, while the host receives the old byte. A host write and a core input read in the same cycle leave the input buffer full with the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_cs | input | 1 | Host access strobe for this channel |
| hst_wr | input | 1 | Host write, qualified by `hst_cs` |
| hst_rd | input | 1 | Host read, qualified by `hst_cs` |
| hst_a | input | 1 | Host port select: 1 command/status, 0 data |
| hst_wdata | input | DW | Host write byte |
| hst_rdata | output | DW | Host read byte (combinational) |
| cor_we | input | 1 | Core register write |
| cor_re | input | 1 | Core register read |
| cor_addr | input | CAW | Core register address |
| cor_wdata | input | DW | Core write byte |
| cor_rdata | output | DW | Core read byte (combinational) |
| irq_ibf | output | 1 | Core interrupt: input buffer full |
| irq_obe | output | 1 | Core interrupt pulse: output buffer emptied |
| host_irq | output | 1 | Host interrupt: output full, plain IRQ |
| host_smi | output | 1 | Host interrupt: output full, SMI |
| host_sci | output | 1 | Host interrupt: output full, SCI |

## Verification
The bench builds the block with its default values, DW = 8 and CAW = 3. At these values every core location from 0 to 7 can be addressed, including the two mask registers and the zero-reading locations. The status byte places all five user bits next to the three hardware bits, so a single host status read shows whether a mask or direct write disturbed a hardware flag. A scoreboard queue carries each expected output byte and its interrupt kind through overwrites and same-cycle collisions of the fill and drain events.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        OB_EMPTY    = 2'd0,
        OB_FULL_IRQ = 2'd1,
        OB_FULL_SMI = 2'd2,
        OB_FULL_SCI = 2'd3
    } ob_state_t;

    typedef enum logic {
        IB_EMPTY = 1'b0,
        IB_FULL  = 1'b1
    } ib_state_t;

    // core register locations
    localparam int unsigned CA_OB_IRQ = 0;
    localparam int unsigned CA_OB_SMI = 1;
    localparam int unsigned CA_OB_SCI = 2;
    localparam int unsigned CA_IB     = 3;
    localparam int unsigned CA_STAT   = 4;
    localparam int unsigned CA_CFG    = 5;
    localparam int unsigned CA_SET    = 6;
    localparam int unsigned CA_CLR    = 7;

    // status bit positions
    localparam int unsigned SB_OBF = 0;
    localparam int unsigned SB_IBF = 1;
    localparam int unsigned SB_CD  = 3;

    // user-owned status bits: 7,6,5,4,2
    localparam logic [7:0] USR_MASK8 = 8'hF4;

endpackage

// File: rtl/mbx_obuf_fsm.sv
module mbx_obuf_fsm
    import mbx_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_wr,
    input  ob_state_t     core_kind,
    input  logic [DW-1:0] core_wdata,
    input  logic          host_take,
    output logic [DW-1:0] ob_byte,
    output logic          obf,
    output logic          line_irq,
    output logic          line_smi,
    output logic          line_sci,
    output logic          obe_pulse
);

    ob_state_t     state_q, state_d;
    logic [DW-1:0] byte_q;
    logic          obe_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OB_EMPTY: begin
                if (core_wr) state_d = core_kind;
            end
            OB_FULL_IRQ, OB_FULL_SMI, OB_FULL_SCI: begin
                if (core_wr)        state_d = core_kind;
                else if (host_take) state_d = OB_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OB_EMPTY;
            byte_q  <= '0;
            obe_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (core_wr) byte_q <= core_wdata;
            obe_q   <= (state_q != OB_EMPTY) && host_take && !core_wr;
        end
    end

    always_comb begin
        obf      = 1'b0;
        line_irq = 1'b0;
        line_smi = 1'b0;
        line_sci = 1'b0;
        unique case (state_q)
            OB_EMPTY:    ;
            OB_FULL_IRQ: begin obf = 1'b1; line_irq = 1'b1; end
            OB_FULL_SMI: begin obf = 1'b1; line_smi = 1'b1; end
            OB_FULL_SCI: begin obf = 1'b1; line_sci = 1'b1; end
        endcase
    end

    assign ob_byte   = byte_q;
    assign obe_pulse = obe_q;

    // R2: a core write always leaves the buffer full
    a_r2_fill_sets_obf: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr |=> obf);

    // R2: a host drain without a fill empties the buffer
    a_r2_take_clears_obf: assert property (@(posedge clk) disable iff (!rst_n)
        (host_take && !core_wr) |=> !obf);

    // R5: the empty pulse only appears with the buffer empty
    a_r5_obe_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        obe_pulse |-> !obf);

    // R6: never two host lines together
    a_r6_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({line_irq, line_smi, line_sci}));

    // R10: fill beats drain
    a_r10_ob_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr && host_take) |=> (obf && ob_byte == $past(core_wdata)));

endmodule

// File: rtl/mbx_ibuf_fsm.sv
module mbx_ibuf_fsm
    import mbx_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_cmd,
    input  logic [DW-1:0] host_wdata,
    input  logic          core_take,
    output logic [DW-1:0] ib_byte,
    output logic          ibf,
    output logic          cmd_flag
);

    ib_state_t     state_q, state_d;
    logic [DW-1:0] byte_q;
    logic          cd_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IB_EMPTY: begin
                if (host_wr) state_d = IB_FULL;
            end
            IB_FULL: begin
                if (!host_wr && core_take) state_d = IB_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IB_EMPTY;
            byte_q  <= '0;
            cd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (host_wr) begin
                byte_q <= host_wdata;
                cd_q   <= host_cmd;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            IB_EMPTY: ibf = 1'b0;
            IB_FULL:  ibf = 1'b1;
        endcase
    end

    assign ib_byte  = byte_q;
    assign cmd_flag = cd_q;

    // R4 / R10: any host write leaves the buffer full
    a_r4_host_write_full: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (ibf && ib_byte == $past(host_wdata)));

    // R3: a lone core read empties the buffer
    a_r3_core_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (core_take && !host_wr) |=> !ibf);

    // R3: the command flag follows the port of the latest host write
    a_r3_cd_tracks_port: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (cmd_flag == $past(host_cmd)));

endmodule

// File: rtl/mbx_status_reg.sv
module mbx_status_reg
    import mbx_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enh,
    input  logic          direct_we,
    input  logic          set_we,
    input  logic          clr_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] usr_bits
);

    localparam logic [DW-1:0] USR_MASK = DW'(USR_MASK8);

    logic [DW-1:0] usr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usr_q <= '0;
        end else if (!enh && direct_we) begin
            usr_q <= wdata & USR_MASK;
        end else if (enh && set_we) begin
            usr_q <= usr_q | (wdata & USR_MASK);
        end else if (enh && clr_we) begin
            usr_q <= usr_q & ~(wdata & USR_MASK);
        end
    end

    assign usr_bits = usr_q;

    // R9: direct status write ignored in enhanced mode
    a_r9_direct_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (enh && direct_we) |=> $stable(usr_bits));

    // R8: hardware-owned positions never held here
    a_r8_user_only: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_bits & ~USR_MASK) == '0);

endmodule

// File: rtl/ec_mailbox.sv
module ec_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned DW  = 8,
    parameter int unsigned CAW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hst_cs,
    input  logic           hst_wr,
    input  logic           hst_rd,
    input  logic           hst_a,
    input  logic [DW-1:0]  hst_wdata,
    output logic [DW-1:0]  hst_rdata,
    input  logic           cor_we,
    input  logic           cor_re,
    input  logic [CAW-1:0] cor_addr,
    input  logic [DW-1:0]  cor_wdata,
    output logic [DW-1:0]  cor_rdata,
    output logic           irq_ibf,
    output logic           irq_obe,
    output logic           host_irq,
    output logic           host_smi,
    output logic           host_sci
);

    localparam logic [CAW-1:0] A_OB_IRQ = CAW'(CA_OB_IRQ);
    localparam logic [CAW-1:0] A_OB_SMI = CAW'(CA_OB_SMI);
    localparam logic [CAW-1:0] A_OB_SCI = CAW'(CA_OB_SCI);
    localparam logic [CAW-1:0] A_IB     = CAW'(CA_IB);
    localparam logic [CAW-1:0] A_STAT   = CAW'(CA_STAT);
    localparam logic [CAW-1:0] A_CFG    = CAW'(CA_CFG);
    localparam logic [CAW-1:0] A_SET    = CAW'(CA_SET);
    localparam logic [CAW-1:0] A_CLR    = CAW'(CA_CLR);

    logic          enh_q;
    logic          ob_wr, ib_take, host_take, host_put;
    ob_state_t     ob_kind;
    logic [DW-1:0] ob_byte, ib_byte, usr_bits, status;
    logic          obf, ibf, cd;

    // decode
    always_comb begin
        ob_wr     = cor_we && (cor_addr == A_OB_IRQ || cor_addr == A_OB_SMI ||
                               cor_addr == A_OB_SCI);
        ib_take   = cor_re && (cor_addr == A_IB);
        host_take = hst_cs && hst_rd && !hst_a;
        host_put  = hst_cs && hst_wr;
        ob_kind   = OB_FULL_IRQ;
        if (enh_q && cor_addr == A_OB_SMI) ob_kind = OB_FULL_SMI;
        if (enh_q && cor_addr == A_OB_SCI) ob_kind = OB_FULL_SCI;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          enh_q <= 1'b0;
        else if (cor_we && cor_addr == A_CFG) enh_q <= cor_wdata[0];
    end

    mbx_obuf_fsm #(.DW(DW)) u_obuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_wr    (ob_wr),
        .core_kind  (ob_kind),
        .core_wdata (cor_wdata),
        .host_take  (host_take),
        .ob_byte    (ob_byte),
        .obf        (obf),
        .line_irq   (host_irq),
        .line_smi   (host_smi),
        .line_sci   (host_sci),
        .obe_pulse  (irq_obe)
    );

    mbx_ibuf_fsm #(.DW(DW)) u_ibuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_put),
        .host_cmd   (hst_a),
        .host_wdata (hst_wdata),
        .core_take  (ib_take),
        .ib_byte    (ib_byte),
        .ibf        (ibf),
        .cmd_flag   (cd)
    );

    mbx_status_reg #(.DW(DW)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .enh       (enh_q),
        .direct_we (cor_we && cor_addr == A_STAT),
        .set_we    (cor_we && cor_addr == A_SET),
        .clr_we    (cor_we && cor_addr == A_CLR),
        .wdata     (cor_wdata),
        .usr_bits  (usr_bits)
    );

    always_comb begin
        status         = usr_bits;
        status[SB_OBF] = obf;
        status[SB_IBF] = ibf;
        status[SB_CD]  = cd;
    end

    always_comb begin
        hst_rdata = '0;
        if (hst_cs && hst_rd) hst_rdata = hst_a ? status : ob_byte;
    end

    always_comb begin
        cor_rdata = '0;
        if (cor_re) begin
            unique case (cor_addr)
                A_OB_IRQ, A_OB_SMI, A_OB_SCI: cor_rdata = ob_byte;
                A_IB:                         cor_rdata = ib_byte;
                A_STAT:                       cor_rdata = status;
                A_CFG:                        cor_rdata = DW'(enh_q);
                default:                      cor_rdata = '0;
            endcase
        end
    end

    assign irq_ibf = ibf;

    // R7: compatible-mode output writes never use SMI or SCI
    a_r7_compat_irq_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh_q && ob_wr) |=> (host_irq && !host_smi && !host_sci));

    // R2: status read leaves the output buffer as it was
    a_r2_status_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_cs && hst_rd && hst_a && !ob_wr) |=> $stable(host_irq | host_smi | host_sci));

endmodule

// File: tb/sim_ec_mailbox.sv
`timescale 1ns/1ps
module sim_ec_mailbox;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       hst_cs, hst_wr, hst_rd, hst_a;
    logic [7:0] hst_wdata, hst_rdata;
    logic       cor_we, cor_re;
    logic [2:0] cor_addr;
    logic [7:0] cor_wdata, cor_rdata;
    logic       irq_ibf, irq_obe, host_irq, host_smi, host_sci;

    always #4 clk = ~clk;

    ec_mailbox u0 (.*);

    int checks = 0;
    int errors = 0;
    logic [10:0] exp_q[$];   // {kind[2:0] = {sci,smi,irq}, byte}
    bit   enh_m   = 0;
    bit   obf_m   = 0;
    logic [7:0] v;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] kind_of(logic [2:0] a);
        if (enh_m && a == 3'd1) return 3'b010;
        if (enh_m && a == 3'd2) return 3'b100;
        return 3'b001;
    endfunction

    task automatic core_wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        cor_we = 1; cor_addr = a; cor_wdata = d;
        @(negedge clk);
        cor_we = 0;
        if (a <= 3'd2) begin
            if (obf_m) void'(exp_q.pop_back());
            exp_q.push_back({kind_of(a), d});
            obf_m = 1;
        end
        if (a == 3'd5) enh_m = d[0];
    endtask

    task automatic core_rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cor_re = 1; cor_addr = a;
        #1 d = cor_rdata;
        @(negedge clk);
        cor_re = 0;
    endtask

    task automatic host_put(logic port, logic [7:0] d);
        @(negedge clk);
        hst_cs = 1; hst_wr = 1; hst_a = port; hst_wdata = d;
        @(negedge clk);
        hst_cs = 0; hst_wr = 0;
    endtask

    task automatic host_stat(output logic [7:0] d);
        @(negedge clk);
        hst_cs = 1; hst_rd = 1; hst_a = 1;
        #1 d = hst_rdata;
        @(negedge clk);
        hst_cs = 0; hst_rd = 0;
    endtask

    // data read: compared by the monitor against the scoreboard
    task automatic host_take();
        @(negedge clk);
        hst_cs = 1; hst_rd = 1; hst_a = 0;
        @(negedge clk);
        hst_cs = 0; hst_rd = 0;
        obf_m = 0;
    endtask

    // R10: core fill and host drain in one cycle
    task automatic both_ob(logic [7:0] d);
        @(negedge clk);
        cor_we = 1; cor_addr = 3'd0; cor_wdata = d;
        hst_cs = 1; hst_rd = 1; hst_a = 0;
        @(negedge clk);
        cor_we = 0; hst_cs = 0; hst_rd = 0;
        exp_q.push_back({kind_of(3'd0), d});
        obf_m = 1;
    endtask

    // R10: host write and core read in one cycle
    task automatic both_ib(logic port, logic [7:0] d, output logic [7:0] got);
        @(negedge clk);
        hst_cs = 1; hst_wr = 1; hst_a = port; hst_wdata = d;
        cor_re = 1; cor_addr = 3'd3;
        #1 got = cor_rdata;
        @(negedge clk);
        hst_cs = 0; hst_wr = 0; cor_re = 0;
    endtask

    // monitor: pops the scoreboard on every host data read
    always @(negedge clk) begin
        #2;
        if (hst_cs && hst_rd && !hst_a) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected data read", 1, 0);
            end else begin
                logic [10:0] it;
                it = exp_q.pop_front();
                chk("R2 host data byte", hst_rdata, it[7:0]);
                chk("R6 host line kind", {host_sci, host_smi, host_irq}, it[10:8]);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; hst_cs = 0; hst_wr = 0; hst_rd = 0; hst_a = 0; hst_wdata = 0;
        cor_we = 0; cor_re = 0; cor_addr = 0; cor_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        #1;
        chk("R1 lines", {host_irq, host_smi, host_sci, irq_ibf, irq_obe}, 0);
        host_stat(v); chk("R1 status", v, 8'h00);
        core_rd(3'd5, v); chk("R1 config", v, 8'h00);

        // R2 fill, quiet status read, drain
        core_wr(3'd0, 8'hA5);
        host_stat(v); chk("R2 status full", v, 8'h01);
        host_stat(v); chk("R2 status read no effect", v, 8'h01);
        chk("R7 irq line", {host_sci, host_smi, host_irq}, 3'b001);
        host_take();
        #1 chk("R5 obe pulse high", irq_obe, 1);
        @(negedge clk); #1 chk("R5 obe pulse gone", irq_obe, 0);
        host_stat(v); chk("R2 status empty", v, 8'h00);
        chk("R2 irq dropped", host_irq, 0);

        // R3 command then data
        host_put(1'b1, 8'h11);
        host_stat(v); chk("R3 cmd status", v, 8'h0A);
        chk("R5 irq_ibf", irq_ibf, 1);
        core_rd(3'd3, v); chk("R3 cmd byte", v, 8'h11);
        host_stat(v); chk("R3 flag kept after empty", v, 8'h08);
        chk("R5 irq_ibf low", irq_ibf, 0);
        host_put(1'b0, 8'h22);
        host_stat(v); chk("R3 data status", v, 8'h02);
        core_rd(3'd3, v); chk("R3 data byte", v, 8'h22);

        // R4 overwrite
        host_put(1'b0, 8'h33);
        host_put(1'b1, 8'h44);
        host_stat(v); chk("R4 still full", v, 8'h0A);
        core_rd(3'd3, v); chk("R4 newest byte", v, 8'h44);

        // R7 compatible aliases
        core_wr(3'd1, 8'h55);
        chk("R7 alias1 irq only", {host_sci, host_smi, host_irq}, 3'b001);
        host_take();
        core_wr(3'd2, 8'h56);
        chk("R7 alias2 irq only", {host_sci, host_smi, host_irq}, 3'b001);
        host_take();

        // R8 direct status write
        core_wr(3'd4, 8'hFF);
        host_stat(v); chk("R8 direct write", v, 8'hFC);
        core_wr(3'd4, 8'h00);
        host_stat(v); chk("R8 direct clear", v, 8'h08);
        core_wr(3'd6, 8'hFF);
        host_stat(v); chk("R9 set ignored in compat", v, 8'h08);

        // R9 enhanced mode
        core_wr(3'd5, 8'h01);
        core_rd(3'd5, v); chk("R9 config", v, 8'h01);
        core_wr(3'd4, 8'hFF);
        host_stat(v); chk("R9 direct ignored", v, 8'h08);
        core_wr(3'd6, 8'h14);
        host_stat(v); chk("R9 set mask", v, 8'h1C);
        core_wr(3'd7, 8'h04);
        host_stat(v); chk("R9 clear bit2", v, 8'h18);
        core_wr(3'd7, 8'hFF);
        host_stat(v); chk("R9 clear all", v, 8'h08);

        // R6 SMI and SCI
        core_wr(3'd1, 8'h66);
        chk("R6 smi", {host_sci, host_smi, host_irq}, 3'b010);
        host_take();
        #1 chk("R6 smi dropped", {host_sci, host_smi, host_irq}, 3'b000);
        core_wr(3'd2, 8'h77);
        chk("R6 sci", {host_sci, host_smi, host_irq}, 3'b100);
        host_take();
        #1 chk("R6 sci dropped", {host_sci, host_smi, host_irq}, 3'b000);

        // R10 collisions
        core_wr(3'd0, 8'h81);
        both_ob(8'h82);
        #1 chk("R10 obuf stays full", host_irq, 1);
        chk("R10 no empty pulse", irq_obe, 0);
        host_stat(v); chk("R10 status obf", v, 8'h09);
        host_take();
        host_put(1'b0, 8'h90);
        both_ib(1'b1, 8'h91, v); chk("R10 core read old", v, 8'h90);
        host_stat(v); chk("R10 ibuf stays full", v, 8'h0A);
        core_rd(3'd3, v); chk("R10 ibuf new byte", v, 8'h91);

        @(negedge clk);
        chk("R2 scoreboard drained", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule